// File: doc/BRIEF.md
# Illegal-Operation Reset Detector

This block sits beside the fetch stage and register file of a small processor core. It watches two things: each fetched 24-bit instruction word, and each occasion on which a working register serves as an address pointer. A fetched word whose top byte carries the reserved code 0x3F cannot be executed. A pointer dereference through a register that has not been loaded since the last reset would use a stale value. Either event makes the block request a device reset from the system reset controller.

The block keeps one "loaded" flag per working register. Reset clears every flag except the one for the stack-pointer register, which the block treats as valid from reset. Any write strobe to a register sets its flag. A pointer use of a register whose flag is clear raises the request. Both kinds of event share one request output, so the reset controller records a single cause for them. The request is a registered pulse that lasts one clock cycle, and the block holds it low while system reset is asserted.

Top module: `illop_reset_detector`

## Requirements
- R1: While `rst_i` is high, `rst_req_o` is low, whatever the other inputs do.
- R2: When `fetch_vld_i` is high and `fetch_word_i[23:16]` equals 0x3F, `rst_req_o` is high in the cycle after that clock edge.
- R3: When `fetch_vld_i` is low, `fetch_word_i` has no effect on `rst_req_o`.
- R4: A valid fetched word whose top byte is any value other than 0x3F (for example 0x3E, 0xBF, 0xFF) does not raise `rst_req_o`.
- R5: After reset, registers 0 to 14 are unloaded: a pointer use (`ptr_use_i` high, index in `ptr_idx_i`) of any of them raises `rst_req_o` in the following cycle.
- R6: Register 15 (the stack pointer) counts as loaded from reset, so a pointer use of it does not raise `rst_req_o`.
- R7: A write strobe `reg_wr_i[n]` marks register n loaded from the next cycle on. Later pointer uses of it do not raise `rst_req_o`. Other registers keep their state.
- R8: A write and a pointer use of the same register in the same cycle count as a loaded use and do not raise `rst_req_o`.
- R9: Every reset returns registers 0 to 14 to the unloaded state, including registers written before the reset.
- R10: `rst_req_o` is never high in two consecutive cycles. An event in the cycle right after a request cycle is dropped.
- R11: An illegal opcode and an unloaded pointer use in the same cycle produce one request on the same output.
- R12: When `ptr_use_i` is low, `ptr_idx_i` has no effect on `rst_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous system reset, active high |
| fetch_word_i | input | 24 | Fetched instruction word |
| fetch_vld_i | input | 1 | Qualifies `fetch_word_i` this cycle |
| reg_wr_i | input | 16 | One write strobe per working register |
| ptr_use_i | input | 1 | A register is used as an address pointer this cycle |
| ptr_idx_i | input | 4 | Index of the register used as a pointer |
| rst_req_o | output | 1 | Single-cycle reset request |

## Verification
Every result appears exactly one clock after the edge that samples the stimulus, because a single register lies between the inputs and `rst_req_o`. A register's loaded flag takes effect at that same edge. The bench drives inputs at a falling edge, lets one rising edge pass, and samples the request at the next falling edge. It then returns the inputs to idle for one cycle, so each table row starts with the request low. Directed sequences check the back-to-back pulse rule by sampling two consecutive cycles, and they check the write-then-use ordering by placing the write one cycle before the use and in the same cycle as the use.

// File: rtl/illop_pkg.sv
package illop_pkg;

   // Which detector fired in a cycle; both map onto the one request output.
   typedef enum logic [1:0] {
      CAUSE_NONE = 2'b00,
      CAUSE_OPC  = 2'b01,
      CAUSE_PTR  = 2'b10,
      CAUSE_BOTH = 2'b11
   } illop_cause_e;

endpackage

// File: rtl/illop_opcode_check.sv
module illop_opcode_check #(
   parameter int          TAG_W   = 8,
   parameter logic [7:0]  TAG_VAL = 8'h3F
) (
   input  logic [TAG_W-1:0] tag_i,
   input  logic             vld_i,
   output logic             illegal_o
);

   generate
      if (TAG_W < 1 || TAG_W > 8) begin : g_bad_tag
         $error("illop_opcode_check: TAG_W must be 1..8");
      end
   endgenerate

   // Only a qualified fetch can trap; bubbles carry stale words.
   assign illegal_o = vld_i && (tag_i == TAG_VAL[TAG_W-1:0]);

endmodule

// File: rtl/illop_reg_tracker.sv
module illop_reg_tracker #(
   parameter int NUM_REGS     = 16,
   parameter int STACK_IDX    = 15,
   parameter bit STACK_PRESET = 1'b1,
   localparam int IDX_W       = $clog2(NUM_REGS)
) (
   input  logic                clk_i,
   input  logic                rst_i,
   input  logic [NUM_REGS-1:0] reg_wr_i,
   input  logic                ptr_use_i,
   input  logic [IDX_W-1:0]    ptr_idx_i,
   output logic                uninit_use_o
);

   generate
      if (NUM_REGS < 2 || (1 << IDX_W) != NUM_REGS) begin : g_bad_regs
         $error("illop_reg_tracker: NUM_REGS must be a power of two >= 2");
      end
      if (STACK_IDX < 0 || STACK_IDX >= NUM_REGS) begin : g_bad_stack
         $error("illop_reg_tracker: STACK_IDX out of range");
      end
   endgenerate

   logic [NUM_REGS-1:0] loaded_q;
   logic [NUM_REGS-1:0] loaded_now;

   // One flag per register; the stack register may be preset at reset.
   for (genvar i = 0; i < NUM_REGS; i++) begin : g_flag
      localparam bit RST_VAL = (i == STACK_IDX) ? STACK_PRESET : 1'b0;
      always_ff @(posedge clk_i) begin
         if (rst_i)
            loaded_q[i] <= RST_VAL;
         else if (reg_wr_i[i])
            loaded_q[i] <= 1'b1;
      end

      // R7: a write strobe leaves the register loaded in the next cycle
      p_wr_sets_r7: assert property (@(posedge clk_i) disable iff (rst_i)
         reg_wr_i[i] |=> loaded_q[i]);
   end

   // A same-cycle write forwards into the check.
   assign loaded_now   = loaded_q | reg_wr_i;
   assign uninit_use_o = ptr_use_i && !loaded_now[ptr_idx_i];

   generate
      if (STACK_PRESET) begin : g_stack_chk
         // R6: the stack register never traps as a pointer
         p_stack_ok_r6: assert property (@(posedge clk_i) disable iff (rst_i)
            (ptr_use_i && ptr_idx_i == IDX_W'(STACK_IDX)) |-> !uninit_use_o);
      end
   endgenerate

endmodule

// File: rtl/illop_pulse_gen.sv
module illop_pulse_gen (
   input  logic clk_i,
   input  logic rst_i,
   input  logic event_i,
   output logic req_o
);

   logic req_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)
         req_q <= 1'b0;
      else
         req_q <= event_i && !req_q;
   end

   assign req_o = req_q;

   // R10: never two request cycles in a row
   p_single_pulse_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      req_o |=> !req_o);

endmodule

// File: rtl/illop_reset_detector.sv
module illop_reset_detector #(
   parameter int          INSTR_W      = 24,
   parameter int          TAG_W        = 8,
   parameter logic [7:0]  TAG_VAL      = 8'h3F,
   parameter int          NUM_REGS     = 16,
   parameter int          STACK_IDX    = 15,
   parameter bit          STACK_PRESET = 1'b1,
   localparam int         IDX_W        = $clog2(NUM_REGS),
   localparam int         LOW_W        = INSTR_W - TAG_W
) (
   input  logic                clk_i,
   input  logic                rst_i,
   input  logic [INSTR_W-1:0]  fetch_word_i,
   input  logic                fetch_vld_i,
   input  logic [NUM_REGS-1:0] reg_wr_i,
   input  logic                ptr_use_i,
   input  logic [IDX_W-1:0]    ptr_idx_i,
   output logic                rst_req_o
);
   import illop_pkg::*;

   generate
      if (LOW_W < 1) begin : g_bad_width
         $error("illop_reset_detector: INSTR_W must exceed TAG_W");
      end
   endgenerate

   logic [TAG_W-1:0] opc_tag;
   logic             unused_low;
   logic             opc_bad;
   logic             ptr_bad;
   illop_cause_e     cause;

   assign opc_tag    = fetch_word_i[INSTR_W-1 -: TAG_W];
   assign unused_low = ^fetch_word_i[LOW_W-1:0];

   illop_opcode_check #(
      .TAG_W   (TAG_W),
      .TAG_VAL (TAG_VAL)
   ) u_opc (
      .tag_i     (opc_tag),
      .vld_i     (fetch_vld_i),
      .illegal_o (opc_bad)
   );

   illop_reg_tracker #(
      .NUM_REGS     (NUM_REGS),
      .STACK_IDX    (STACK_IDX),
      .STACK_PRESET (STACK_PRESET)
   ) u_trk (
      .clk_i        (clk_i),
      .rst_i        (rst_i),
      .reg_wr_i     (reg_wr_i),
      .ptr_use_i    (ptr_use_i),
      .ptr_idx_i    (ptr_idx_i),
      .uninit_use_o (ptr_bad)
   );

   assign cause = illop_cause_e'({ptr_bad, opc_bad});

   illop_pulse_gen u_pulse (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .event_i (cause != CAUSE_NONE),
      .req_o   (rst_req_o)
   );

   // R2: a qualified reserved opcode yields a request next cycle
   p_opcode_req_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (fetch_vld_i && opc_tag == TAG_VAL[TAG_W-1:0] && !rst_req_o) |=> rst_req_o);

   // R11: every request traces back to one of the two detectors
   p_req_has_cause_r11: assert property (@(posedge clk_i) disable iff (rst_i)
      rst_req_o |-> $past(opc_bad || ptr_bad));

endmodule

// File: tb/tb_illop_reset_detector.sv
module tb_illop_reset_detector;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 11;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [23:0] word = '0;
   logic        vld = 1'b0;
   logic [15:0] wr = '0;
   logic        use_p = 1'b0;
   logic [3:0]  idx = '0;
   logic        req;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   illop_reset_detector dut (
      .clk_i        (clk),
      .rst_i        (rst),
      .fetch_word_i (word),
      .fetch_vld_i  (vld),
      .reg_wr_i     (wr),
      .ptr_use_i    (use_p),
      .ptr_idx_i    (idx),
      .rst_req_o    (req)
   );

   // Row: {req number[7:0], vld, word[23:0], ptr use, idx[3:0], expected}
   // All rows run from the post-reset state with no writes.
   localparam logic [38:0] VEC [NV] = '{
      {8'd2,  1'b1, 24'h3F0000, 1'b0, 4'd0,  1'b1},   // R2
      {8'd3,  1'b0, 24'h3F1234, 1'b0, 4'd0,  1'b0},   // R3
      {8'd4,  1'b1, 24'h3E0000, 1'b0, 4'd0,  1'b0},   // R4
      {8'd4,  1'b1, 24'hBF0000, 1'b0, 4'd0,  1'b0},   // R4
      {8'd4,  1'b1, 24'hFFFFFF, 1'b0, 4'd0,  1'b0},   // R4
      {8'd2,  1'b1, 24'h3FFFFF, 1'b0, 4'd0,  1'b1},   // R2
      {8'd5,  1'b0, 24'h000000, 1'b1, 4'd0,  1'b1},   // R5
      {8'd5,  1'b0, 24'h000000, 1'b1, 4'd14, 1'b1},   // R5
      {8'd6,  1'b0, 24'h000000, 1'b1, 4'd15, 1'b0},   // R6
      {8'd12, 1'b0, 24'h000000, 1'b0, 4'd3,  1'b0},   // R12
      {8'd11, 1'b1, 24'h3F0000, 1'b1, 4'd4,  1'b1}    // R11
   };

   task automatic check(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: rst_req_o=%b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic idle();
      vld = 1'b0; word = '0; wr = '0; use_p = 1'b0; idx = '0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; idle();
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      // R1: hold reset with an illegal opcode and unloaded pointer use present
      rst = 1'b1; vld = 1'b1; word = 24'h3F0000; use_p = 1'b1; idx = 4'd2;
      repeat (3) @(negedge clk);
      check(req, 1'b0, "R1 request low in reset");
      @(negedge clk);
      check(req, 1'b0, "R1 request low in reset, later cycle");
      idle();
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(req, 1'b0, "R1 request low after release");

      // Table walk: drive one cycle, sample after one edge, idle one cycle
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         vld   = VEC[i][30];
         word  = VEC[i][29:6];
         use_p = VEC[i][5];
         idx   = VEC[i][4:1];
         @(negedge clk);
         check(req, VEC[i][0], $sformatf("R%0d row %0d", VEC[i][38:31], i));
         idle();
      end

      // R7: write register 3, use it next cycle; register 2 still traps
      do_reset();
      wr = 16'h0008;
      @(negedge clk);
      wr = '0; use_p = 1'b1; idx = 4'd3;
      @(negedge clk);
      check(req, 1'b0, "R7 written register used");
      idle();
      @(negedge clk);
      use_p = 1'b1; idx = 4'd2;
      @(negedge clk);
      check(req, 1'b1, "R7 neighbour still unloaded");
      idle();
      @(negedge clk);

      // R8: write and use register 5 in the same cycle
      wr = 16'h0020; use_p = 1'b1; idx = 4'd5;
      @(negedge clk);
      check(req, 1'b0, "R8 same-cycle write and use");
      idle();
      @(negedge clk);

      // R9: register 3 was loaded; after reset it traps again
      do_reset();
      use_p = 1'b1; idx = 4'd3;
      @(negedge clk);
      check(req, 1'b1, "R9 reset clears loaded flag");
      idle();
      @(negedge clk);

      // R10: illegal opcode held valid for three cycles gives 1,0,1
      vld = 1'b1; word = 24'h3F00AA;
      @(negedge clk);
      check(req, 1'b1, "R10 first pulse");
      @(negedge clk);
      check(req, 1'b0, "R10 no second consecutive cycle");
      @(negedge clk);
      check(req, 1'b1, "R10 pulse again after gap");
      idle();
      @(negedge clk);
      check(req, 1'b0, "R10 quiet after stimulus ends");

      // R11: combined event gives a single pulse
      vld = 1'b1; word = 24'h3F0000; use_p = 1'b1; idx = 4'd7;
      @(negedge clk);
      idle();
      check(req, 1'b1, "R11 combined event");
      @(negedge clk);
      check(req, 1'b0, "R11 only one pulse");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule